// File: doc/BRIEF.md
# Reloading Countdown Timer Bank

The block holds sixteen independent 32-bit down-counting channels behind a small 16-bit register bus. A shared prescaler turns the system clock into a periodic tick (480 ns at the default setting). On each tick, every enabled channel counts down by one. When a channel reaches its terminal count, it copies its preset back into its current value and sets its own status flag.

Each channel has a mode bit. In loop mode the channel keeps running, so it produces a status event every `preset` ticks. In one-shot mode the channel also drops its own enable at terminal count. Because the preset has already been reloaded by then, software can restart the channel just by enabling it again. Channels are switched on and off through two write-one registers: one sets enable bits and the other clears them. Status flags are cleared by reading the status register. The status flags, gated by a per-channel allow mask, are combined into one active-low interrupt line.

Software programs a channel by writing its preset, which also primes the current count. It then chooses a mode and an allow bit, enables the channel, and services the interrupt line by reading the status register.

Top module: `cdt_bank`

## Requirements
- R1: After reset, the enable, mode, mask and status vectors are all zero, every preset and current value is zero, and `irq_n` is high.
- R2: A tick occurs once every `TICK_DIV` clock cycles. An enabled channel whose count is above 1 decreases by exactly one per tick. A disabled channel keeps its count unchanged.
- R3: The preset of channel n is written at byte offset 0x240+4n (low half) and 0x242+4n (high half). A write to either half also loads the whole updated preset into the current count. The current count of channel n reads at 0x200+4n (low half) and 0x202+4n (high half).
- R4: A tick that finds an enabled channel at count 1 or 0 loads that channel's preset into its count and sets status bit n.
- R5: With mode bit n = 0, the channel stays enabled after terminal count and keeps looping, so terminal events repeat every `preset` ticks.
- R6: With mode bit n = 1, terminal count clears enable bit n and the count then holds at the reloaded preset. Setting the enable bit again restarts the countdown from the preset.
- R7: Writing to offset 0x50 sets every enable bit whose data bit is 1. Writing to offset 0x52 clears every enable bit whose data bit is 1. Data bits of 0 change nothing. A read of either offset returns the enable vector. A set write wins over a one-shot self-clear in the same cycle.
- R8: A read of offset 0x58 returns the status vector and clears it. A status bit set by a terminal count in the same cycle as that read stays set.
- R9: `irq_n` is low exactly when some status bit and its mask bit are both 1. The mask at offset 0x56 never changes the status bits.
- R10: The mode vector at offset 0x54 and the mask vector at offset 0x56 can be written and read back. Bit n of each vector belongs to channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; needed only for the read side effect on status |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data decoded from `bus_addr` in the same cycle |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
Two events can land in the same clock edge: a tick that takes a channel to terminal count, which sets its status bit, and a status-register read, which clears all status bits. The bench provokes this by watching a channel's count until it reaches 1. From that moment, the next tick is exactly `TICK_DIV` cycles away, so the bench holds the read strobe on the status offset across that exact edge. It passes only if the value returned by the read still shows the old, clear bit, the status bit is set after the edge, and the interrupt line is low.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // Register byte offsets; channel windows use a 4-byte stride (low half, then high half)
  localparam int OFS_EN_SET   = 'h050;
  localparam int OFS_EN_CLR   = 'h052;
  localparam int OFS_MODE     = 'h054;
  localparam int OFS_MASK     = 'h056;
  localparam int OFS_STAT     = 'h058;
  localparam int OFS_CUR_BASE = 'h200;
  localparam int OFS_PRE_BASE = 'h240;
  localparam int CH_STRIDE    = 4;
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int TICK_DIV = 48
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (TICK_DIV > 1) begin : g_spacing_chk
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/cdt_channel.sv
module cdt_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [CNT_W/2-1:0] wdata,
  output logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count,
  output logic             term
);
  localparam int H = CNT_W / 2;

  logic [CNT_W-1:0] preset_q, preset_d, count_q, count_d;

  always_comb begin
    term     = run && tick && (count_q <= CNT_W'(1));
    preset_d = preset_q;
    if (wr_lo) preset_d[H-1:0]     = wdata;
    if (wr_hi) preset_d[CNT_W-1:H] = wdata;
    count_d = count_q;
    if (wr_lo || wr_hi)  count_d = preset_d;
    else if (term)       count_d = preset_q;
    else if (run && tick) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
      count_q  <= '0;
    end else begin
      preset_q <= preset_d;
      count_q  <= count_d;
    end
  end

  assign preset = preset_q;
  assign count  = count_q;

  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> $stable(count_q));
  assert_reload_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !wr_lo && !wr_hi) |=> (count_q == $past(preset_q)));
  assert_write_primes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo || wr_hi) |=> (count_q == preset_q));
endmodule

// File: rtl/cdt_bank.sv
module cdt_bank
  import cdt_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int BUS_W    = 16,
  parameter int ADDR_W   = 12,
  parameter int TICK_DIV = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_n
);
  localparam int CNT_W   = 2 * BUS_W;
  localparam int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int WIN     = NUM_CH * CH_STRIDE;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rsync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  logic tick;
  cdt_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n_s), .tick(tick)
  );

  // address decode
  logic               in_cur, in_pre, hi_half;
  logic [CH_BITS-1:0] ch_idx;
  logic               wr_set, wr_clr, wr_mode, wr_mask, rd_stat;
  logic [NUM_CH-1:0]  set_bits, clr_bits;

  always_comb begin
    in_cur  = (bus_addr >= ADDR_W'(OFS_CUR_BASE)) && (bus_addr < ADDR_W'(OFS_CUR_BASE + WIN));
    in_pre  = (bus_addr >= ADDR_W'(OFS_PRE_BASE)) && (bus_addr < ADDR_W'(OFS_PRE_BASE + WIN));
    ch_idx  = bus_addr[CH_BITS+1:2];
    hi_half = bus_addr[1];
    wr_set  = bus_wr && (bus_addr == ADDR_W'(OFS_EN_SET));
    wr_clr  = bus_wr && (bus_addr == ADDR_W'(OFS_EN_CLR));
    wr_mode = bus_wr && (bus_addr == ADDR_W'(OFS_MODE));
    wr_mask = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
    rd_stat = bus_rd && (bus_addr == ADDR_W'(OFS_STAT));
    set_bits = wr_set ? bus_wdata[NUM_CH-1:0] : '0;
    clr_bits = wr_clr ? bus_wdata[NUM_CH-1:0] : '0;
  end

  // channels
  logic [NUM_CH-1:0] pre_wr_lo, pre_wr_hi, term_v;
  logic [CNT_W-1:0]  pre_arr [NUM_CH];
  logic [CNT_W-1:0]  cur_arr [NUM_CH];
  logic [NUM_CH-1:0] en_q, en_d, mode_q, mode_d, mask_q, mask_d, stat_q, stat_d;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign pre_wr_lo[i] = bus_wr && in_pre && (ch_idx == CH_BITS'(i)) && !hi_half;
      assign pre_wr_hi[i] = bus_wr && in_pre && (ch_idx == CH_BITS'(i)) &&  hi_half;
      cdt_channel #(.CNT_W(CNT_W)) u_ch (
        .clk(clk), .rst_n(rst_n_s), .tick(tick), .run(en_q[i]),
        .wr_lo(pre_wr_lo[i]), .wr_hi(pre_wr_hi[i]), .wdata(bus_wdata),
        .preset(pre_arr[i]), .count(cur_arr[i]), .term(term_v[i])
      );
    end
  endgenerate

  // control and status next state
  always_comb begin
    en_d   = (en_q & ~clr_bits & ~(term_v & mode_q)) | set_bits;
    mode_d = wr_mode ? bus_wdata[NUM_CH-1:0] : mode_q;
    mask_d = wr_mask ? bus_wdata[NUM_CH-1:0] : mask_q;
    stat_d = (rd_stat ? '0 : stat_q) | term_v;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_q   <= '0;
      mode_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      mask_q <= mask_d;
      stat_q <= stat_d;
    end
  end

  assign irq_n = ~|(stat_q & mask_q);

  // read mux
  logic [CNT_W-1:0] cur_sel, pre_sel;
  always_comb begin
    cur_sel   = cur_arr[ch_idx];
    pre_sel   = pre_arr[ch_idx];
    bus_rdata = '0;
    if (in_cur)
      bus_rdata = hi_half ? cur_sel[CNT_W-1:BUS_W] : cur_sel[BUS_W-1:0];
    else if (in_pre)
      bus_rdata = hi_half ? pre_sel[CNT_W-1:BUS_W] : pre_sel[BUS_W-1:0];
    else if (bus_addr == ADDR_W'(OFS_EN_SET) || bus_addr == ADDR_W'(OFS_EN_CLR))
      bus_rdata[NUM_CH-1:0] = en_q;
    else if (bus_addr == ADDR_W'(OFS_MODE))
      bus_rdata[NUM_CH-1:0] = mode_q;
    else if (bus_addr == ADDR_W'(OFS_MASK))
      bus_rdata[NUM_CH-1:0] = mask_q;
    else if (bus_addr == ADDR_W'(OFS_STAT))
      bus_rdata[NUM_CH-1:0] = stat_q;
  end

  assert_oneshot_stops_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> ((en_q & $past(term_v & mode_q & ~set_bits)) == '0));
  assert_loop_stays_on_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> ((~en_q & $past(term_v & ~mode_q & ~clr_bits)) == '0));
  assert_new_status_kept_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> ((stat_q & $past(term_v)) == $past(term_v)));
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_stat |=> ((stat_q & ~$past(term_v)) == '0));
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mask_q == '0) |-> irq_n);
endmodule

// File: tb/cdt_bank_tb.sv
module cdt_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdt_bank #(.NUM_CH(16), .BUS_W(16), .ADDR_W(12), .TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  function automatic logic [11:0] cur_a(int ch, bit hi);
    return 12'(32'h200 + ch * 4 + (hi ? 2 : 0));
  endfunction
  function automatic logic [11:0] pre_a(int ch, bit hi);
    return 12'(32'h240 + ch * 4 + (hi ? 2 : 0));
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(logic [11:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_now(logic [11:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic set_preset(int ch, logic [31:0] v);
    wr(pre_a(ch, 1'b0), v[15:0]);
    wr(pre_a(ch, 1'b1), v[31:16]);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    @(negedge clk);
    peek(12'h050, d); check(d == 16'h0, "R1 enable", d, 0);
    peek(12'h054, d); check(d == 16'h0, "R1 mode", d, 0);
    peek(12'h056, d); check(d == 16'h0, "R1 mask", d, 0);
    peek(12'h058, d); check(d == 16'h0, "R1 status", d, 0);
    peek(cur_a(7, 1'b1), d); check(d == 16'h0, "R1 count", d, 0);
    peek(pre_a(15, 1'b0), d); check(d == 16'h0, "R1 preset", d, 0);
    check(irq_n == 1'b1, "R1 irq_n", 32'(irq_n), 1);
  endtask

  task automatic t_preset_load;
    logic [15:0] d;
    set_preset(3, 32'hABCD_1234);
    peek(cur_a(3, 1'b0), d); check(d == 16'h1234, "R3 count low", d, 16'h1234);
    peek(cur_a(3, 1'b1), d); check(d == 16'hABCD, "R3 count high", d, 16'hABCD);
    peek(pre_a(3, 1'b1), d); check(d == 16'hABCD, "R3 preset high", d, 16'hABCD);
    repeat (20) @(negedge clk);
    peek(cur_a(3, 1'b0), d); check(d == 16'h1234, "R2 disabled holds", d, 16'h1234);
  endtask

  task automatic t_enable_regs;
    logic [15:0] d;
    wr(12'h050, 16'h0009);
    peek(12'h050, d); check(d == 16'h0009, "R7 set", d, 9);
    peek(12'h052, d); check(d == 16'h0009, "R7 read at clear offset", d, 9);
    wr(12'h050, 16'h0000);
    peek(12'h050, d); check(d == 16'h0009, "R7 zero set no effect", d, 9);
    wr(12'h052, 16'h0001);
    peek(12'h050, d); check(d == 16'h0008, "R7 clear", d, 8);
    wr(12'h052, 16'h0000);
    peek(12'h050, d); check(d == 16'h0008, "R7 zero clear no effect", d, 8);
    wr(12'h052, 16'hFFFF);
    peek(12'h050, d); check(d == 16'h0000, "R7 clear all", d, 0);
  endtask

  task automatic t_mode_mask;
    logic [15:0] d;
    wr(12'h054, 16'hA5A5);
    peek(12'h054, d); check(d == 16'hA5A5, "R10 mode", d, 16'hA5A5);
    wr(12'h056, 16'h0F0F);
    peek(12'h056, d); check(d == 16'h0F0F, "R10 mask", d, 16'h0F0F);
    wr(12'h054, 16'h0000);
    wr(12'h056, 16'h0000);
  endtask

  task automatic t_decrement;
    logic [15:0] a, b;
    set_preset(3, 32'd100);
    wr(12'h050, 16'h0008);
    peek(cur_a(3, 1'b0), a);
    repeat (10 * DIV) @(negedge clk);
    peek(cur_a(3, 1'b0), b);
    check(a - b == 16'd10, "R2 ten ticks", 32'(a - b), 10);
    wr(12'h052, 16'h0008);
    peek(cur_a(3, 1'b0), a);
    repeat (3 * DIV) @(negedge clk);
    peek(cur_a(3, 1'b0), b);
    check(a == b, "R2 stop after disable", b, a);
  endtask

  task automatic t_counter_loop;
    logic [15:0] d;
    int c;
    set_preset(1, 32'd3);
    wr(12'h056, 16'h0002);
    rd(12'h058, d);
    wr(12'h050, 16'h0002);
    c = 0;
    #1;
    while (irq_n && c < 200) begin @(negedge clk); #1; c++; end
    check(!irq_n, "R4 terminal raises irq", 32'(irq_n), 0);
    peek(cur_a(1, 1'b0), d); check(d == 16'd3, "R4 reload", d, 3);
    rd_now(12'h058, d); check(d == 16'h0002, "R4 status bit", d, 2);
    #1;
    check(irq_n, "R8 read clears", 32'(irq_n), 1);
    c = 1;
    while (irq_n && c < 200) begin @(negedge clk); #1; c++; end
    check(c == 3 * DIV, "R5 loop period", 32'(c), 32'(3 * DIV));
    peek(12'h050, d); check(d == 16'h0002, "R5 stays enabled", d, 2);
    wr(12'h052, 16'h0002);
    rd(12'h058, d);
    wr(12'h056, 16'h0000);
  endtask

  task automatic t_timer;
    logic [15:0] d;
    int c;
    set_preset(2, 32'd2);
    wr(12'h054, 16'h0004);
    wr(12'h056, 16'h0004);
    rd(12'h058, d);
    wr(12'h050, 16'h0004);
    c = 0;
    #1;
    while (irq_n && c < 200) begin @(negedge clk); #1; c++; end
    peek(12'h050, d); check(d == 16'h0000, "R6 enable self-clears", d, 0);
    peek(cur_a(2, 1'b0), d); check(d == 16'd2, "R6 reloaded", d, 2);
    repeat (5 * DIV) @(negedge clk);
    peek(cur_a(2, 1'b0), d); check(d == 16'd2, "R6 stopped", d, 2);
    wr(12'h050, 16'h0004);
    repeat (DIV) @(negedge clk);
    peek(cur_a(2, 1'b0), d); check(d == 16'd1, "R6 restart from preset", d, 1);
    wr(12'h052, 16'h0004);
    rd(12'h058, d);
    wr(12'h054, 16'h0000);
    wr(12'h056, 16'h0000);
  endtask

  task automatic t_same_cycle;
    logic [15:0] d;
    int c;
    set_preset(4, 32'd5);
    wr(12'h056, 16'h0010);
    rd(12'h058, d);
    wr(12'h050, 16'h0010);
    c = 0;
    peek(cur_a(4, 1'b0), d);
    while (d != 16'd1 && c < 200) begin @(negedge clk); peek(cur_a(4, 1'b0), d); c++; end
    repeat (DIV - 1) @(negedge clk);
    rd_now(12'h058, d);
    check(d == 16'h0000, "R8 read returns old status", d, 0);
    peek(12'h058, d); check(d == 16'h0010, "R8 status kept on collision", d, 16'h10);
    check(!irq_n, "R9 irq on collision", 32'(irq_n), 0);
    peek(cur_a(4, 1'b0), d); check(d == 16'd5, "R4 reload on collision", d, 5);
    wr(12'h052, 16'h0010);
  endtask

  task automatic t_mask;
    logic [15:0] d;
    wr(12'h056, 16'h0000);
    #1;
    check(irq_n, "R9 masked quiet", 32'(irq_n), 1);
    peek(12'h058, d); check(d == 16'h0010, "R9 mask keeps status", d, 16'h10);
    wr(12'h056, 16'h0010);
    #1;
    check(!irq_n, "R9 unmask asserts", 32'(irq_n), 0);
    rd(12'h058, d);
    #1;
    check(irq_n, "R8 R9 read clears irq", 32'(irq_n), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_preset_load();
    t_enable_regs();
    t_mode_mask();
    t_decrement();
    t_counter_loop();
    t_timer();
    t_same_cycle();
    t_mask();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule